// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is a single pulse-width modulation channel with an 8-bit counter. A prescaled tick input paces the counter. The counter runs in one of two modes. In edge mode it counts upward and wraps. In symmetric mode it climbs to the period value and then falls back to zero. The output is high while the count is below the duty value.

Software reaches the channel through a small register port: a control word, a period, a duty value and the counter itself. Each written value lands first in a shadow copy. The shadow is copied into the working copy only at safe points: the close of a period, a counter write, or while the channel is off. As a result, each output cycle comes entirely from either the old settings or the new ones.

Register selector codes: 0 is control (bit 0 run, bit 1 symmetric mode), 1 is period, 2 is duty, 3 is counter.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset every register reads 0 and the output is low.
- R2: A write to selector 3 clears the counter to 0 on the next clock whatever the data. The same write loads the period and duty shadows into the working copies.
- R3: While control bit 0 is 0, the following hold:
  - a period or duty write reaches the working copy on the same clock;
  - the counter holds at 0;
  - the output is low.
- R4: While running, a period or duty write changes only the shadow. The working copy keeps its old value until the period closes (or R2 or R3 applies).
- R5: Reading selector 1 or 2 returns the last value written, not the working copy.
- R6: In edge mode (control bit 1 = 0) the counter steps 0,1,…,P−1 and wraps, so a period lasts P ticks.
- R7: In symmetric mode the counter rises from 0 to P and then falls back to 0, so a period lasts 2·P ticks.
- R8: With duty D and period P where 0 < D < P, the output is high exactly while the count is below D.
- R9: If D ≥ P the output stays high. If P = 0 the output stays high and the counter does not move.
- R10: The counter changes only on clocks where the tick input is high, unless R2 or R3 applies.
- R11: Reading selector 3 returns the live count, and reading selector 0 returns the control word in its low two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled channel-clock enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register selector, shared by read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions check several rules on every clock:
- the output is low when the channel is off and high when the period is zero;
- the counter and working period stay still on clocks without a tick;
- a counter write clears the count;
- a period write reads back at once.

The exact shape of the waveform can only be shown by the bench's scenarios, which compare every clock against a behavioural model. These scenarios cover the period lengths in both modes, the moment a buffered value takes effect, and the full-duty and zero-period cases.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PER  = 2'd1,
        SEL_DUTY = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic center;
        logic run;
    } chan_cfg_t;

    // Output level for a running channel: R8/R9 rules.
    function automatic logic wave_level(input logic [15:0] cnt,
                                        input logic [15:0] per,
                                        input logic [15:0] duty);
        return (per == '0) || (duty >= per) || (cnt < duty);
    endfunction

endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output chan_cfg_t    cfg,
    output logic [W-1:0] shd_per,
    output logic [W-1:0] shd_duty,
    output logic [W-1:0] act_per,
    output logic [W-1:0] act_duty
);
    logic [W-1:0] per_nxt, duty_nxt;

    always_comb begin
        per_nxt  = shd_per;
        duty_nxt = shd_duty;
        if (wr_en && sel == SEL_PER)  per_nxt  = wr_data;
        if (wr_en && sel == SEL_DUTY) duty_nxt = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            shd_per  <= '0;
            shd_duty <= '0;
            act_per  <= '0;
            act_duty <= '0;
        end else begin
            shd_per  <= per_nxt;
            shd_duty <= duty_nxt;
            if (wr_en && sel == SEL_CTRL) begin
                cfg.run    <= wr_data[0];
                cfg.center <= wr_data[1];
            end
            if (load) begin
                act_per  <= per_nxt;
                act_duty <= duty_nxt;
            end
        end
    end
endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         center,
    input  logic         tick,
    input  logic         clear,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         down;
    logic [W:0]   cnt_inc;
    logic         step;
    logic         at_top;

    assign cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign step    = run && tick && (per != '0);
    assign at_top  = cnt_inc >= {1'b0, per};

    always_comb begin
        if (!step)       wrap = 1'b0;
        else if (center) wrap = down && (cnt <= ONE);
        else             wrap = at_top;
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (step) begin
            if (!center) begin
                down <= 1'b0;
                cnt  <= at_top ? '0 : cnt_inc[W-1:0];
            end else if (!down) begin
                if (at_top) begin
                    cnt  <= per;
                    down <= 1'b1;
                end else begin
                    cnt <= cnt_inc[W-1:0];
                end
            end else if (cnt <= ONE) begin
                cnt  <= '0;
                down <= 1'b0;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
    import pwm_dbuf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         pwm_out
);
    reg_sel_e     sel;
    chan_cfg_t    cfg;
    logic [W-1:0] shd_per, shd_duty, act_per, act_duty, cnt;
    logic         clear, wrap, load;

    assign sel   = reg_sel_e'(addr);
    assign clear = wr_en && (sel == SEL_CNT);
    assign load  = clear || !cfg.run || wrap;

    pwm_dbuf_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
        .load(load), .cfg(cfg), .shd_per(shd_per), .shd_duty(shd_duty),
        .act_per(act_per), .act_duty(act_duty)
    );

    pwm_dbuf_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .run(cfg.run), .center(cfg.center),
        .tick(tick), .clear(clear), .per(act_per), .cnt(cnt), .wrap(wrap)
    );

    always_comb begin
        pwm_out = cfg.run && wave_level(16'(cnt), 16'(act_per), 16'(act_duty));
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_data = {{(W-2){1'b0}}, cfg.center, cfg.run};
            SEL_PER:  rd_data = shd_per;
            SEL_DUTY: rd_data = shd_duty;
            default:  rd_data = cnt;
        endcase
    end
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic         pwm_out,
    input logic         run,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_per
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == 2'd3);

    a_r3_off_low: assert property (@(posedge clk) disable iff (rst)
        !run |-> !pwm_out);

    a_r9_zero_period_high: assert property (@(posedge clk) disable iff (rst)
        (run && act_per == '0) |-> pwm_out);

    a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !cnt_wr) |=> $stable(cnt));

    a_r4_active_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !cnt_wr) |=> $stable(act_per));

    a_r2_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == '0));

    a_r5_per_readback: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1) |=> (addr != 2'd1 || rd_data == $past(wr_data)));
endmodule

bind pwm_dbuf_chan pwm_dbuf_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out),
    .run(cfg.run), .cnt(cnt), .act_per(act_per)
);

// File: tb/pwm_dbuf_chan_test.sv
module pwm_dbuf_chan_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst = 1, tick = 0, wr_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       pwm_out;
    int checks = 0, failures = 0;
    bit done = 0;

    // Reference model state
    int m_cnt, m_down, m_aper, m_aduty, m_sper, m_sduty, m_run, m_ctr;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dbuf_chan uut (.clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out));

    function automatic void model_reset();
        m_cnt = 0; m_down = 0; m_aper = 0; m_aduty = 0;
        m_sper = 0; m_sduty = 0; m_run = 0; m_ctr = 0;
    endfunction

    function automatic void model_clock(input bit w, input int a, input int d, input bit t);
        int np = (w && a == 1) ? d : m_sper;
        int nd = (w && a == 2) ? d : m_sduty;
        bit ld = 0;
        if (w && a == 3) begin m_cnt = 0; m_down = 0; ld = 1; end
        else if (!m_run) begin m_cnt = 0; m_down = 0; ld = 1; end
        else if (t && m_aper != 0) begin
            if (!m_ctr) begin
                m_down = 0;
                if (m_cnt + 1 >= m_aper) begin m_cnt = 0; ld = 1; end
                else m_cnt++;
            end else if (!m_down) begin
                if (m_cnt + 1 >= m_aper) begin m_cnt = m_aper; m_down = 1; end
                else m_cnt++;
            end else begin
                if (m_cnt <= 1) begin m_cnt = 0; m_down = 0; ld = 1; end
                else m_cnt--;
            end
        end
        if (ld) begin m_aper = np; m_aduty = nd; end
        m_sper = np; m_sduty = nd;
        if (w && a == 0) begin m_run = d & 1; m_ctr = (d >> 1) & 1; end
    endfunction

    function automatic int model_out();
        if (!m_run) return 0;
        return (m_aper == 0 || m_aduty >= m_aper || m_cnt < m_aduty) ? 1 : 0;
    endfunction

    function automatic int model_rd(input int a);
        case (a)
            0: return m_ctr * 2 + m_run;
            1: return m_sper;
            2: return m_sduty;
            default: return m_cnt;
        endcase
    endfunction

    task automatic compare(input string tag);
        int eo = model_out();
        int er = model_rd(addr);
        checks++;
        if (pwm_out !== eo[0]) begin
            failures++;
            $display("FAIL %s pwm_out actual=%0b expected=%0d t=%0t", tag, pwm_out, eo, $time);
        end
        checks++;
        if (rd_data !== er[7:0]) begin
            failures++;
            $display("FAIL %s rd_data[sel %0d] actual=%0d expected=%0d t=%0t", tag, addr, rd_data, er, $time);
        end
    endtask

    task automatic step(input bit w, input int a, input int d, input bit t, input string tag);
        @(negedge clk);
        wr_en = w; addr = a[1:0]; wr_data = d[7:0]; tick = t;
        @(posedge clk);
        model_clock(w, a, d, t);
        #1;
        compare(tag);
    endtask

    task automatic run_ticks(input int n, input int sel, input string tag);
        for (int i = 0; i < n; i++) step(0, sel, 0, 1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state of every register and the output
        for (int a = 0; a < 4; a++) step(0, a, 0, 1, "R1");
        // R3/R5: disabled writes pass straight through and read back
        step(1, 1, 5, 1, "R3");
        step(1, 2, 2, 1, "R3");
        step(0, 1, 0, 1, "R5");
        step(0, 2, 0, 0, "R5");
        step(0, 3, 0, 1, "R3");
        // R6/R8: edge mode, P=5 D=2
        step(1, 0, 1, 0, "R11");
        run_ticks(12, 3, "R6");
        run_ticks(3, 0, "R8");
        // R4: buffered period while running
        step(1, 1, 3, 1, "R4");
        step(1, 2, 1, 1, "R4");
        run_ticks(6, 1, "R5");
        run_ticks(10, 3, "R4");
        // R10: sparse ticks
        for (int i = 0; i < 12; i++) step(0, 3, 0, i % 3 == 0, "R10");
        // R2: counter write mid-period with new shadow values
        step(1, 1, 7, 1, "R4");
        step(1, 2, 3, 1, "R4");
        step(1, 3, 8'hA5, 1, "R2");
        run_ticks(16, 3, "R2");
        // R7: symmetric mode, P=4 D=2
        step(1, 0, 0, 1, "R3");
        step(1, 1, 4, 1, "R3");
        step(1, 2, 2, 1, "R3");
        step(1, 0, 3, 1, "R11");
        run_ticks(20, 3, "R7");
        step(1, 1, 2, 1, "R4");
        run_ticks(14, 3, "R7");
        for (int i = 0; i < 10; i++) step(0, 3, 0, i % 2 == 1, "R10");
        // R9: duty >= period
        step(1, 2, 9, 1, "R9");
        run_ticks(10, 3, "R9");
        // R9: zero period holds high, counter idle
        step(1, 1, 0, 1, "R9");
        run_ticks(10, 3, "R9");
        step(1, 3, 0, 1, "R9");
        run_ticks(6, 3, "R9");
        // R6: boundary P=1 edge mode, D=0
        step(1, 0, 0, 1, "R3");
        step(1, 1, 1, 1, "R3");
        step(1, 2, 0, 1, "R3");
        step(1, 0, 1, 1, "R6");
        run_ticks(6, 3, "R6");
        // R3: disable mid-run
        step(1, 1, 6, 1, "R4");
        run_ticks(2, 3, "R4");
        step(1, 0, 0, 1, "R3");
        run_ticks(4, 3, "R3");
        step(0, 1, 0, 1, "R5");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule